// File: doc/BRIEF.md
# Packed Fuse Map Unpacker

This block expands a compacted one-time-programmable record stream into a flat logical byte map. A single start pulse launches it. It first writes 0xFF into every logical location. It then walks the physical byte array from address 0, fetching one byte at a time through a synchronous read port with one cycle of latency. It decodes each record header and copies the data words that the header enables into the logical map, using an address-and-data write port.

Every record begins with a header. A short header is one byte and can name blocks 0 to 15. A long header is two bytes and can name a block up to 127. After the header, each of its four word slots is present only if its mask bit is 0, and each present slot carries two bytes. The scan stops normally at an end marker, or when the read pointer lands exactly on the scan limit at a header boundary. The scan limit is the physical size minus a protected tail. The scan aborts with an error if a word would run past the scan limit or past the end of the logical map. A one-cycle done pulse closes every run, and the error flag holds its value until the next start.

Top module: `fuse_unpack`

## Requirements
- R1: After an accepted start, every logical byte reads 0xFF unless a record word overwrites it during that run.
- R2: If bits [4:0] of the first header byte are not 5'h0F, the header is one byte long. The block number is bits [7:4] of that byte, and the word mask is bits [3:0].
- R3: If bits [4:0] of the first header byte are 5'h0F, the header is two bytes long. The block number is {second[7:4], first[7:5]}, and the word mask is bits [3:0] of the second byte.
- R4: Word slots are handled in order 0 to 3. A mask bit of 1 means the slot is absent and uses no physical bytes. A mask bit of 0 means the next two physical bytes go to logical addresses block*8+slot*2 and block*8+slot*2+1.
- R5: A first header byte of 0xFF ends the run without error. A long-form first byte followed by a second byte of 0xFF also ends the run without error.
- R6: Only addresses below PHYS_SIZE-PROT_SIZE are scanned. A pointer equal to that limit at a header boundary ends the run without error, and bytes beyond the limit do not affect the map.
- R7: A present word whose second byte would lie at or above the scan limit ends the run with err=1, and that word is not written.
- R8: A present word whose logical address plus one is at or above LOG_SIZE ends the run with err=1, and that word is not written.
- R9: done is high for exactly one cycle per run. err reads 0 after reset, keeps its value after done, and is cleared by the next accepted start.
- R10: A start pulse that arrives while a run is in progress is ignored. It does not change the map or the cycle at which done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| phy_addr | output | $clog2(PHYS_SIZE) | Physical read address |
| phy_data | input | 8 | Physical byte, valid one cycle after its address |
| log_we | output | 1 | Logical write strobe |
| log_addr | output | $clog2(LOG_SIZE) | Logical write address |
| log_data | output | 8 | Logical write data |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run was aborted by a bounds violation |

## Verification
A stale pointer or a slot counter that has drifted makes every later record land at the wrong logical address or start from the wrong byte. This shows up as map mismatches within one run, and the bench compares the whole map after each done. A wrong block or mask latch shows up in the words of the very record that was decoded. A wrong stop decision shows up as an extra or missing write, or as an error flag that differs from the bench model at the done pulse. Sweeps cover every one-byte header value and every second header byte under two long-form first bytes.

// File: rtl/fuse_unpack_pkg.sv
package fuse_unpack_pkg;

  localparam int BLK_W = 7;
  localparam int IDX_W = 11;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_H1_REQ,
    ST_H1_USE,
    ST_H2_USE,
    ST_WORD,
    ST_W_LO,
    ST_W_HI,
    ST_FINISH
  } ctl_state_e;

  // a first byte whose low five bits are 01111 announces a second byte
  function automatic logic is_long_hdr(input logic [7:0] h1);
    return h1[4:0] == 5'h0F;
  endfunction

  function automatic logic [BLK_W-1:0] long_blk(input logic [7:0] h1, input logic [7:0] h2);
    return {h2[7:4], h1[7:5]};
  endfunction

  function automatic logic [BLK_W-1:0] short_blk(input logic [7:0] h1);
    return {3'b000, h1[7:4]};
  endfunction

  // logical byte address of slot wi inside block blk
  function automatic logic [IDX_W-1:0] word_base(input logic [BLK_W-1:0] blk, input logic [1:0] wi);
    return {1'b0, blk, 3'b000} + {8'd0, wi, 1'b0};
  endfunction

endpackage

// File: rtl/fuse_hdr_decode.sv
module fuse_hdr_decode
  import fuse_unpack_pkg::*;
(
  input  logic [7:0]       h1,
  input  logic [7:0]       h2,
  output logic             long_fmt,
  output logic [BLK_W-1:0] blk,
  output logic [3:0]       wen_n,
  output logic             stop_short,
  output logic             stop_long
);

  always_comb begin
    long_fmt   = is_long_hdr(h1);
    stop_short = (h1 == 8'hFF);
    stop_long  = long_fmt && (h2 == 8'hFF);
    blk        = long_fmt ? long_blk(h1, h2) : short_blk(h1);
    wen_n      = long_fmt ? h2[3:0] : h1[3:0];
  end

endmodule

// File: rtl/fuse_word_guard.sv
module fuse_word_guard
  import fuse_unpack_pkg::*;
#(
  parameter int PTR_W    = 8,
  parameter int LIMIT    = 56,
  parameter int LOG_SIZE = 64
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic [BLK_W-1:0] blk,
  input  logic [1:0]       wi,
  output logic [IDX_W-1:0] log_idx,
  output logic             phy_over,
  output logic             log_over
);

  localparam logic [31:0] LIM_U = 32'(LIMIT);
  localparam logic [31:0] LOG_U = 32'(LOG_SIZE);

  always_comb begin
    log_idx  = word_base(blk, wi);
    phy_over = (32'(ptr) + 32'd2) > LIM_U;
    log_over = (32'(log_idx) + 32'd2) > LOG_U;
  end

endmodule

// File: rtl/fuse_unpack_ctrl.sv
module fuse_unpack_ctrl
  import fuse_unpack_pkg::*;
#(
  parameter int PHYS_SIZE = 64,
  parameter int PROT_SIZE = 8,
  parameter int LOG_SIZE  = 64,
  localparam int PAW   = $clog2(PHYS_SIZE),
  localparam int LAW   = $clog2(LOG_SIZE),
  localparam int PTR_W = PAW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [PAW-1:0]   phy_addr,
  input  logic [7:0]       phy_data,
  output logic             log_we,
  output logic [LAW-1:0]   log_addr,
  output logic [7:0]       log_data,
  output logic             done,
  output logic             err,
  output logic [7:0]       dec_h1,
  output logic [7:0]       dec_h2,
  input  logic             long_fmt,
  input  logic [BLK_W-1:0] dec_blk,
  input  logic [3:0]       dec_wen_n,
  input  logic             stop_short,
  input  logic             stop_long,
  output logic [PTR_W-1:0] ptr,
  output logic [BLK_W-1:0] cur_blk,
  output logic [1:0]       cur_wi,
  input  logic [IDX_W-1:0] log_idx,
  input  logic             phy_over,
  input  logic             log_over
);

  localparam logic [31:0]    LIM_U   = 32'(PHYS_SIZE - PROT_SIZE);
  localparam logic [31:0]    LOG_U   = 32'(LOG_SIZE);
  localparam logic [LAW-1:0] FILL_LAST = LAW'(LOG_SIZE - 1);

  ctl_state_e       state;
  logic [LAW-1:0]   fill_q;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       hdr1_q;
  logic [BLK_W-1:0] blk_q;
  logic [3:0]       wen_q;
  logic [1:0]       wi_q;
  logic             err_q;

  // named events for the assertions
  logic start_acc, word_present, err_set, last_word, at_limit;
  logic [PTR_W-1:0] rd_ptr;

  assign start_acc    = (state == ST_IDLE) && start;
  assign word_present = !wen_q[wi_q];
  assign err_set      = (state == ST_WORD) && word_present && (phy_over || log_over);
  assign last_word    = (wi_q == 2'd3);
  assign at_limit     = 32'(ptr_q) >= LIM_U;

  // second header byte and second word byte are fetched one ahead
  assign rd_ptr   = ((state == ST_H1_USE) || (state == ST_W_LO)) ? ptr_q + PTR_W'(1) : ptr_q;
  assign phy_addr = PAW'(rd_ptr);
  assign dec_h1   = (state == ST_H1_USE) ? phy_data : hdr1_q;
  assign dec_h2   = phy_data;
  assign ptr      = ptr_q;
  assign cur_blk  = blk_q;
  assign cur_wi   = wi_q;
  assign done     = (state == ST_FINISH);
  assign err      = err_q;

  always_comb begin
    log_we   = 1'b0;
    log_addr = '0;
    log_data = 8'hFF;
    case (state)
      ST_FILL: begin
        log_we   = 1'b1;
        log_addr = fill_q;
      end
      ST_W_LO: begin
        log_we   = 1'b1;
        log_addr = LAW'(log_idx);
        log_data = phy_data;
      end
      ST_W_HI: begin
        log_we   = 1'b1;
        log_addr = LAW'(log_idx + IDX_W'(1));
        log_data = phy_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      fill_q <= '0;
      ptr_q  <= '0;
      hdr1_q <= 8'h00;
      blk_q  <= '0;
      wen_q  <= 4'hF;
      wi_q   <= 2'd0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_FILL;
          fill_q <= '0;
          err_q  <= 1'b0;
        end
        ST_FILL: begin
          if (fill_q == FILL_LAST) begin
            state <= ST_H1_REQ;
            ptr_q <= '0;
          end else begin
            fill_q <= fill_q + LAW'(1);
          end
        end
        ST_H1_REQ: state <= at_limit ? ST_FINISH : ST_H1_USE;
        ST_H1_USE: begin
          hdr1_q <= phy_data;
          if (stop_short) begin
            state <= ST_FINISH;
          end else if (long_fmt) begin
            state <= ST_H2_USE;
          end else begin
            blk_q <= dec_blk;
            wen_q <= dec_wen_n;
            ptr_q <= ptr_q + PTR_W'(1);
            wi_q  <= 2'd0;
            state <= ST_WORD;
          end
        end
        ST_H2_USE: begin
          if (stop_long) begin
            state <= ST_FINISH;
          end else begin
            blk_q <= dec_blk;
            wen_q <= dec_wen_n;
            ptr_q <= ptr_q + PTR_W'(2);
            wi_q  <= 2'd0;
            state <= ST_WORD;
          end
        end
        ST_WORD: begin
          if (!word_present) begin
            if (last_word) state <= ST_H1_REQ;
            else           wi_q  <= wi_q + 2'd1;
          end else if (phy_over || log_over) begin
            err_q <= 1'b1;
            state <= ST_FINISH;
          end else begin
            state <= ST_W_LO;
          end
        end
        ST_W_LO: state <= ST_W_HI;
        ST_W_HI: begin
          ptr_q <= ptr_q + PTR_W'(2);
          if (last_word) begin
            state <= ST_H1_REQ;
          end else begin
            wi_q  <= wi_q + 2'd1;
            state <= ST_WORD;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R7: the word being copied never reaches the scan limit
  p_word_below_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_W_LO) |-> ((32'(ptr_q) + 32'd1) < LIM_U));

  // R8: the upper byte of a copied word stays inside the logical map
  p_log_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_W_HI) |-> ((32'(log_idx) + 32'd1) < LOG_U));

  // R9: done never lasts two cycles
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: err moves only on an accepted start or an abort
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_acc && !err_set) |=> $stable(err));

  // R10: a start during a run never re-enters the fill phase
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state != ST_IDLE) && (state != ST_FILL)) |=> (state != ST_FILL));

  // R1: the fill phase hands over to header parsing at physical address 0
  p_fill_handover_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_FILL) && (fill_q == FILL_LAST)) |=> ((state == ST_H1_REQ) && (ptr_q == '0)));

endmodule

// File: rtl/fuse_unpack.sv
module fuse_unpack
  import fuse_unpack_pkg::*;
#(
  parameter int PHYS_SIZE = 64,
  parameter int PROT_SIZE = 8,
  parameter int LOG_SIZE  = 64,
  localparam int PAW   = $clog2(PHYS_SIZE),
  localparam int LAW   = $clog2(LOG_SIZE),
  localparam int PTR_W = PAW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic [PAW-1:0] phy_addr,
  input  logic [7:0]     phy_data,
  output logic           log_we,
  output logic [LAW-1:0] log_addr,
  output logic [7:0]     log_data,
  output logic           done,
  output logic           err
);

  logic [7:0]       dec_h1, dec_h2;
  logic             long_fmt, stop_short, stop_long;
  logic [BLK_W-1:0] dec_blk, cur_blk;
  logic [3:0]       dec_wen_n;
  logic [PTR_W-1:0] ptr;
  logic [1:0]       cur_wi;
  logic [IDX_W-1:0] log_idx;
  logic             phy_over, log_over;

  fuse_hdr_decode u_dec (
    .h1(dec_h1), .h2(dec_h2), .long_fmt(long_fmt), .blk(dec_blk),
    .wen_n(dec_wen_n), .stop_short(stop_short), .stop_long(stop_long)
  );

  fuse_word_guard #(
    .PTR_W(PTR_W), .LIMIT(PHYS_SIZE - PROT_SIZE), .LOG_SIZE(LOG_SIZE)
  ) u_guard (
    .ptr(ptr), .blk(cur_blk), .wi(cur_wi), .log_idx(log_idx),
    .phy_over(phy_over), .log_over(log_over)
  );

  fuse_unpack_ctrl #(
    .PHYS_SIZE(PHYS_SIZE), .PROT_SIZE(PROT_SIZE), .LOG_SIZE(LOG_SIZE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phy_addr(phy_addr), .phy_data(phy_data),
    .log_we(log_we), .log_addr(log_addr), .log_data(log_data),
    .done(done), .err(err),
    .dec_h1(dec_h1), .dec_h2(dec_h2), .long_fmt(long_fmt), .dec_blk(dec_blk),
    .dec_wen_n(dec_wen_n), .stop_short(stop_short), .stop_long(stop_long),
    .ptr(ptr), .cur_blk(cur_blk), .cur_wi(cur_wi), .log_idx(log_idx),
    .phy_over(phy_over), .log_over(log_over)
  );

endmodule

// File: tb/fuse_unpack_test.sv
`timescale 1ns/1ps
module fuse_unpack_test;

  localparam int PHYS = 64;
  localparam int PROT = 8;
  localparam int LOGS = 64;
  localparam int LIM  = PHYS - PROT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] phy_addr;
  logic [7:0] phy_data;
  logic       log_we;
  logic [5:0] log_addr;
  logic [7:0] log_data;
  logic       done, err;

  logic [7:0] phy [PHYS];
  logic [7:0] logm [LOGS];
  logic [7:0] exp_log [LOGS];
  logic       exp_err;
  logic       clr_log = 1'b0;
  int checks = 0, fails = 0, cycles = 0, last_lat = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fuse_unpack #(.PHYS_SIZE(PHYS), .PROT_SIZE(PROT), .LOG_SIZE(LOGS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr), .phy_data(phy_data),
    .log_we(log_we), .log_addr(log_addr), .log_data(log_data), .done(done), .err(err)
  );

  always @(posedge clk) phy_data <= phy[phy_addr];

  always @(posedge clk) begin
    if (clr_log) begin
      for (int i = 0; i < LOGS; i++) logm[i] <= 8'h00;
    end else if (log_we) begin
      logm[log_addr] <= log_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of the record walk
  task automatic model();
    int p, h1, h2, b, m, li;
    exp_err = 1'b0;
    for (int i = 0; i < LOGS; i++) exp_log[i] = 8'hFF;
    p = 0;
    while (p < LIM) begin
      h1 = int'(phy[p]);
      h2 = int'(phy[p + 1]);
      if (h1 == 255) break;
      if ((h1 % 32) == 15) begin
        if (h2 == 255) break;
        b = (h2 / 16) * 8 + h1 / 32;
        m = h2 % 16;
        p = p + 2;
      end else begin
        b = h1 / 16;
        m = h1 % 16;
        p = p + 1;
      end
      for (int w = 0; w < 4; w++) begin
        if (((m >> w) & 1) == 1) continue;
        li = b * 8 + w * 2;
        if (p + 2 > LIM || li + 2 > LOGS) begin
          exp_err = 1'b1;
          return;
        end
        exp_log[li]     = phy[p];
        exp_log[li + 1] = phy[p + 1];
        p = p + 2;
      end
    end
  endtask

  task automatic fill_phy(input logic [7:0] v);
    for (int i = 0; i < PHYS; i++) phy[i] = v;
  endtask

  task automatic run(input string req, input bit poke);
    int lat, bad, first;
    bit seen;
    model();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0; seen = 0;
    while (!seen && lat < 3000) begin
      if (poke && lat == 5) start = 1'b1;
      else start = 1'b0;
      if (done) seen = 1;
      else begin @(negedge clk); lat++; end
    end
    start = 1'b0;
    last_lat = lat;
    check(seen, {req, " done"}, 0, 1);
    check(err == exp_err, {req, " err"}, int'(err), int'(exp_err));
    @(negedge clk);
    check(!done, "R9 done pulse width", int'(done), 0);
    check(err == exp_err, "R9 err held", int'(err), int'(exp_err));
    bad = 0; first = -1;
    for (int i = 0; i < LOGS; i++)
      if (logm[i] !== exp_log[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " map"}, int'(logm[first]), int'(exp_log[first]));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000 && !finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lat_ref;
    fill_phy(8'hFF);
    repeat (3) @(negedge clk);
    check(!done && !err && !log_we, "R9 reset state", int'({done, err, log_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5: empty array leaves an all-0xFF map
    run("R1/R5 empty", 1'b0);

    // R2 R4 R8: every one-byte-wide first header value
    for (int h = 0; h < 256; h++) begin
      fill_phy(8'hFF);
      phy[0] = 8'(h);
      for (int j = 1; j <= 8; j++) phy[j] = 8'(8'hA0 + j);
      run(((h % 32) == 15) ? "R3/R4 swept" : "R2/R4/R8 swept", 1'b0);
    end

    // R3 R5 R8: every second header byte under two long-form first bytes
    for (int k = 0; k < 2; k++)
      for (int h = 0; h < 256; h++) begin
        fill_phy(8'hFF);
        phy[0] = (k == 0) ? 8'h0F : 8'hEF;
        phy[1] = 8'(h);
        for (int j = 2; j <= 9; j++) phy[j] = 8'(8'h30 + j);
        run("R3/R5/R8 long sweep", 1'b0);
      end

    // R6: records fill exactly to the scan limit, tail bytes are ignored
    fill_phy(8'h00);
    for (int r = 0; r < 6; r++) begin
      phy[r * 9] = 8'(r * 16);
      for (int j = 1; j <= 8; j++) phy[r * 9 + j] = 8'(r * 16 + j);
    end
    phy[54] = 8'h7F; phy[55] = 8'h7F;
    run("R6 exact limit", 1'b0);
    lat_ref = last_lat;

    // R10: start during the run changes neither map nor latency
    run("R10 busy start", 1'b1);
    check(last_lat == lat_ref, "R10 latency", last_lat, lat_ref);

    // R7: word crossing the limit aborts
    phy[55] = 8'h7E;
    run("R7 limit crossing", 1'b0);

    // R9: next start clears err
    fill_phy(8'hFF);
    run("R9 err cleared", 1'b0);

    // R4: skipped slots with long header on a high block
    fill_phy(8'hFF);
    phy[0] = 8'hEF; phy[1] = 8'h05;
    for (int j = 2; j <= 5; j++) phy[j] = 8'(8'h50 + j);
    run("R4 masked slots", 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule